// File: doc/BRIEF.md
# Dual-Host Edge-Triggered Interrupt Collector

This block gathers a parameterised number of interrupt sources (4 to 18) and presents them to two independent host lines. Every source passes through a two-flop synchronizer and an edge detector. A shared edge-select array chooses, per source, whether rising edges, falling edges, both, or neither raise an event. Each event is recorded in the pending status of both lines. Each line keeps its own status bits, its own mask bits and its own active-low interrupt output.

Software reaches the block through a byte-wide synchronous register port with separate read and write strobes. Read data is registered. A control register chooses how status is acknowledged: either a read of a status byte clears what it returned, or software writes ones to clear. It also chooses whether a second event on a source that is already pending is kept for later or dropped. A per-line test register lets software set status bits directly.

Top module: `irqc_top`

## Requirements
- R1: After reset both interrupt outputs are high, every valid mask bit reads 1, and status, edge-select and control read 0.
- R2: For source k, bit 2*(k mod 4)+1 of edge-select byte 0x1C + k/4 enables rising edges. A rising edge of the synchronized input sets the source's status bit on both lines.
- R3: For source k, bit 2*(k mod 4) of the same edge-select byte enables falling edges. A falling edge then sets the status bit on both lines.
- R4: A source whose two edge-select bits are both 0 never becomes pending from input changes.
- R5: The two lines have separate status and mask bits. Events reach both lines, and masking or clearing on one line leaves the other unchanged.
- R6: Interrupt output L is low exactly when line L has a status bit set whose mask bit is 0. A mask bit of 1 hides that source from the output.
- R7: With control bit 0 set, reading a status byte returns it and clears the bits it returned. Writes to status bytes are then ignored.
- R8: With control bit 0 clear, writing a 1 to a status bit clears it. Reads leave status unchanged.
- R9: With control bit 1 clear, an event on a source that is already pending is held, and the source becomes pending again after the first clear. With control bit 1 set, such an event is dropped and any held event is discarded.
- R10: An event in the same cycle as a clear of that source is never lost. It remains as the pending bit, or as the held event if one was already waiting.
- R11: Writing a 1 to a test-register bit sets that status bit on that line in the next cycle. Writing 0 has no effect, and test bytes read as 0.
- R12: The register map is: control 0x00; line 0 status 0x04, mask 0x08, test 0x14; line 1 status 0x0C, mask 0x10, test 0x18; edge-select 0x1C. Multi-byte registers are little-endian, with byte i holding sources 8i..8i+7 and the least significant bit first. Bits at or above the source count (twice the count for edge-select) read 0 and ignore writes. Read data appears in the cycle after the read strobe.
- R13: An input level change first sampled at clock edge t is reflected in status and in the interrupt output after edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source levels |
| addr_i | input | 6 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per byte |
| rd_en_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 2 | Active-low interrupt, one per host line |

## Verification
The hard case is a detected edge and a clear of the same source landing in the same clock cycle. That clear may be a status write in write-one-to-clear mode or a status read in clear-on-read mode. The bench makes a source pending through the test register, toggles its input, and issues the clear after a delay swept across the edge's arrival cycle, so the clear lands before, on and after the event. It runs the sweep with holding of a second event both enabled and disabled. A behavioural model kept in step on every clock judges the status read back after each clear. Hand-computed values confirm that the coincident case leaves the source pending rather than clearing it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 6;

    // register byte addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_STAT0 = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_MASK0 = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_STAT1 = 6'h0C;
    localparam logic [ADDR_W-1:0] ADR_MASK1 = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_TEST0 = 6'h14;
    localparam logic [ADDR_W-1:0] ADR_TEST1 = 6'h18;
    localparam logic [ADDR_W-1:0] ADR_EDGE  = 6'h1C;

    // control register fields
    localparam int CTL_COR  = 0;
    localparam int CTL_PDIS = 1;
    localparam int CTL_W    = 2;

    localparam int NUM_LINES = 2;

    function automatic logic [ADDR_W-1:0] pick_base(input int line,
                                                    input logic [ADDR_W-1:0] b0,
                                                    input logic [ADDR_W-1:0] b1);
        return (line == 0) ? b0 : b1;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N = 18
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] lvl;
        logic [N-1:0] hist;
    } sync_t;

    sync_t sy_q, sy_d;

    always_comb begin
        sy_d.meta = src_i;
        sy_d.lvl  = sy_q.meta;
        sy_d.hist = sy_q.lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign rise_o = sy_q.lvl & ~sy_q.hist;
    assign fall_o = ~sy_q.lvl & sy_q.hist;

    // R13: an edge is reported only one cycle after the level moved through the first stage
    a_r13_edge_from_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o != '0) |-> ((rise_o & ~$past(sy_q.meta)) == '0));

endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 18,
    localparam int SEL_W = 2 * N
) (
    input  logic [N-1:0]     rise_i,
    input  logic [N-1:0]     fall_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N-1:0]     evt_o
);

    for (genvar k = 0; k < N; k++) begin : g_src
        // upper bit of the pair arms rising edges, lower bit arms falling edges
        assign evt_o[k] = (rise_i[k] & sel_i[2*k+1]) | (fall_i[k] & sel_i[2*k]);
    end

endmodule

// File: rtl/irqc_line.sv
module irqc_line #(
    parameter int N = 18
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         pdis_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] stat_o,
    output logic         irq_n_o
);

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] extra;
    } line_t;

    line_t ln_q, ln_d;

    always_comb begin
        // a clear hands the held event over to the pending bit; new events always land
        ln_d.pend = (ln_q.pend & ~clr_i) | (ln_q.extra & clr_i) | set_i;
        if (pdis_i) begin
            ln_d.extra = '0;
        end else begin
            ln_d.extra = (ln_q.extra & ~clr_i)
                       | (ln_q.pend & set_i & ~clr_i)
                       | (ln_q.extra & set_i & clr_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ln_q <= '0;
        else         ln_q <= ln_d;
    end

    assign stat_o  = ln_q.pend;
    assign irq_n_o = ~|(ln_q.pend & ~mask_i);

    // R9: a held event exists only behind a pending bit
    a_r9_held_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ln_q.extra & ~ln_q.pend) == '0);

    // R9: with holding disabled nothing is held one cycle later
    a_r9_pdis_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdis_i |=> (ln_q.extra == '0));

    // R10: every event is pending in the next cycle, clear or not
    a_r10_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    // R7: a clear with no new and no held event empties the bit
    a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~set_i & ~ln_q.extra) != '0)
        |=> ((stat_o & $past(clr_i & ~set_i & ~ln_q.extra)) == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 18
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [5:0]         addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic [1:0]         irq_n_o
);

    localparam int IXR_BYTES = (NUM_SRC + 7) / 8;
    localparam int EDGE_BITS = 2 * NUM_SRC;
    localparam int PAD_LSB   = NUM_SRC % 8;

    typedef struct packed {
        logic [CTL_W-1:0]                      ctrl;
        logic [NUM_LINES-1:0][NUM_SRC-1:0]     mask;
        logic [EDGE_BITS-1:0]                  esel;
        logic [7:0]                            rdata;
    } regs_t;

    regs_t rg_q, rg_d;

    logic [NUM_SRC-1:0]                  rise_w, fall_w, evt_w;
    logic [NUM_LINES-1:0][NUM_SRC-1:0]   stat_w, set_w, clr_w;

    initial begin
        a_r12_param_range: assert (NUM_SRC >= 4 && NUM_SRC <= 18);
    end

    irqc_sync #(.N(NUM_SRC)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    irqc_edge #(.N(NUM_SRC)) u_edge (
        .rise_i (rise_w),
        .fall_i (fall_w),
        .sel_i  (rg_q.esel),
        .evt_o  (evt_w)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irqc_line #(.N(NUM_SRC)) u_line (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .set_i   (set_w[l]),
            .clr_i   (clr_w[l]),
            .pdis_i  (rg_q.ctrl[CTL_PDIS]),
            .mask_i  (rg_q.mask[l]),
            .stat_o  (stat_w[l]),
            .irq_n_o (irq_n_o[l])
        );
    end

    // per-line set and clear strobes decoded from the byte port
    always_comb begin
        logic hit_st, hit_ts;
        set_w = '0;
        clr_w = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                hit_st = (addr_i == pick_base(l, ADR_STAT0, ADR_STAT1) + 6'(k / 8));
                hit_ts = (addr_i == pick_base(l, ADR_TEST0, ADR_TEST1) + 6'(k / 8));
                set_w[l][k] = evt_w[k] | (wr_en_i & hit_ts & wdata_i[k % 8]);
                if (rg_q.ctrl[CTL_COR]) begin
                    clr_w[l][k] = rd_en_i & hit_st;
                end else begin
                    clr_w[l][k] = wr_en_i & hit_st & wdata_i[k % 8];
                end
            end
        end
    end

    // register writes and the read multiplexer
    always_comb begin
        logic       hit_rs, hit_rm, hit_re;
        logic [7:0] rbyte;
        rg_d  = rg_q;
        rbyte = '0;

        if (addr_i == ADR_CTRL) begin
            rbyte[CTL_W-1:0] = rg_q.ctrl;
            if (wr_en_i) rg_d.ctrl = wdata_i[CTL_W-1:0];
        end

        for (int l = 0; l < NUM_LINES; l++) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                hit_rs = (addr_i == pick_base(l, ADR_STAT0, ADR_STAT1) + 6'(k / 8));
                hit_rm = (addr_i == pick_base(l, ADR_MASK0, ADR_MASK1) + 6'(k / 8));
                if (hit_rs) rbyte[k % 8] = stat_w[l][k];
                if (hit_rm) begin
                    rbyte[k % 8] = rg_q.mask[l][k];
                    if (wr_en_i) rg_d.mask[l][k] = wdata_i[k % 8];
                end
            end
        end

        for (int j = 0; j < EDGE_BITS; j++) begin
            hit_re = (addr_i == ADR_EDGE + 6'(j / 8));
            if (hit_re) begin
                rbyte[j % 8] = rg_q.esel[j];
                if (wr_en_i) rg_d.esel[j] = wdata_i[j % 8];
            end
        end

        if (rd_en_i) rg_d.rdata = rbyte;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q.ctrl  <= '0;
            rg_q.mask  <= '1;
            rg_q.esel  <= '0;
            rg_q.rdata <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign rdata_o = rg_q.rdata;

    // R6: an output can only be released by a register access in the cycle before
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
        a_r6_release_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(irq_n_o[l]) |-> $past(rd_en_i || wr_en_i));
    end

    // R12: unused upper bits of the last status byte always read back as zero
    if (PAD_LSB != 0) begin : g_pad
        a_r12_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rd_en_i) && ($past(addr_i) == ADR_STAT0 + 6'(IXR_BYTES - 1)))
            |-> ((rdata_o >> PAD_LSB) == 8'h00));
    end

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int N = 18;

    // bench-side register map
    localparam logic [5:0] B_CTRL = 6'h00, B_ST0 = 6'h04, B_MK0 = 6'h08,
                           B_ST1  = 6'h0C, B_MK1 = 6'h10, B_TS0 = 6'h14,
                           B_TS1  = 6'h18, B_ED  = 6'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [5:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = '0;
    wire  [7:0]   rdata;
    wire  [1:0]   irq_n;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk; // 100 MHz

    irqc_top #(.NUM_SRC(N)) i_irqc_top (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .src_i   (src),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_n_o (irq_n)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0]   m_s1, m_s2, m_s3, m_ev;
    bit [N-1:0]   m_st [2];
    bit [N-1:0]   m_bf [2];
    bit [N-1:0]   m_mk [2];
    bit [2*N-1:0] m_ed;
    bit [1:0]     m_ctl;
    bit [7:0]     m_rd;
    bit           m_rdchk;
    bit           m_setb, m_clrb;

    function automatic logic [5:0] lb(input int l, input logic [5:0] a, input logic [5:0] b);
        return (l == 0) ? a : b;
    endfunction

    function automatic bit [7:0] model_byte(input logic [5:0] a);
        bit [7:0] r = 8'h00;
        if (a == B_CTRL) r[1:0] = m_ctl;
        for (int l = 0; l < 2; l++)
            for (int k = 0; k < N; k++) begin
                if (a == lb(l, B_ST0, B_ST1) + 6'(k / 8)) r[k % 8] = m_st[l][k];
                if (a == lb(l, B_MK0, B_MK1) + 6'(k / 8)) r[k % 8] = m_mk[l][k];
            end
        for (int j = 0; j < 2 * N; j++)
            if (a == B_ED + 6'(j / 8)) r[j % 8] = m_ed[j];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            for (int l = 0; l < 2; l++) begin
                m_st[l] = '0; m_bf[l] = '0; m_mk[l] = '1;
            end
            m_ed = '0; m_ctl = '0; m_rdchk = 1'b0;
        end else begin
            for (int k = 0; k < N; k++)
                m_ev[k] = (m_s2[k] & !m_s3[k] & m_ed[2*k+1]) | (!m_s2[k] & m_s3[k] & m_ed[2*k]);
            m_rdchk = rd_en;
            if (rd_en) m_rd = model_byte(addr);
            for (int l = 0; l < 2; l++) begin
                for (int k = 0; k < N; k++) begin
                    m_setb = m_ev[k] | (wr_en && addr == lb(l, B_TS0, B_TS1) + 6'(k / 8) && wdata[k % 8]);
                    if (m_ctl[0]) m_clrb = rd_en && addr == lb(l, B_ST0, B_ST1) + 6'(k / 8);
                    else          m_clrb = wr_en && addr == lb(l, B_ST0, B_ST1) + 6'(k / 8) && wdata[k % 8];
                    if (m_clrb && m_st[l][k]) begin
                        if (m_bf[l][k]) begin m_st[l][k] = 1'b1;   m_bf[l][k] = m_setb; end
                        else            begin m_st[l][k] = m_setb; m_bf[l][k] = 1'b0;   end
                    end else if (m_setb) begin
                        if (m_st[l][k]) m_bf[l][k] = 1'b1;
                        else            m_st[l][k] = 1'b1;
                    end
                    if (m_ctl[1]) m_bf[l][k] = 1'b0;
                    if (wr_en && addr == lb(l, B_MK0, B_MK1) + 6'(k / 8)) m_mk[l][k] = wdata[k % 8];
                end
            end
            for (int j = 0; j < 2 * N; j++)
                if (wr_en && addr == B_ED + 6'(j / 8)) m_ed[j] = wdata[j % 8];
            if (wr_en && addr == B_CTRL) m_ctl = wdata[1:0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit [1:0] e;
        if (rst_n) begin
            for (int l = 0; l < 2; l++) e[l] = ((m_st[l] & ~m_mk[l]) == '0);
            checks++;
            if (irq_n !== e) begin
                errors++;
                $display("FAIL R6 model irq_n: actual %b expected %b", irq_n, e);
            end
            if (m_rdchk) begin
                checks++;
                if (rdata !== m_rd) begin
                    errors++;
                    $display("FAIL %s model rdata: actual %02h expected %02h", cur_req, rdata, m_rd);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rdchk(input logic [5:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        cur_req = req;
        rd(a, d);
        chk(d, exp, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset values
        chk({6'b0, irq_n}, 8'h03, "R1");
        rdchk(B_MK0, 8'hFF, "R1");
        rdchk(B_MK1 + 6'd2, 8'h03, "R1");
        rdchk(B_ST0, 8'h00, "R1");
        rdchk(B_ED, 8'h00, "R1");
        rdchk(B_CTRL, 8'h00, "R1");

        // R2 rising on source 0, R5 separate lines
        wr(B_ED, 8'h02);
        wr(B_ED + 6'd1, 8'h04);       // source 5 falling
        wr(B_MK0, 8'hFE);
        rdchk(B_ED, 8'h02, "R2");
        @(negedge clk); src[0] = 1'b1;
        tick(4);
        chk({7'b0, irq_n[0]}, 8'h00, "R2");
        chk({7'b0, irq_n[1]}, 8'h01, "R5");
        rdchk(B_ST1, 8'h01, "R5");

        // R7 clear-on-read
        wr(B_CTRL, 8'h01);
        rdchk(B_ST0, 8'h01, "R7");
        rdchk(B_ST0, 8'h00, "R7");
        chk({7'b0, irq_n[0]}, 8'h01, "R7");

        // R3 falling on source 5, masked on line 0
        @(negedge clk); src[5] = 1'b1;
        tick(4);
        rdchk(B_ST0, 8'h00, "R3");
        @(negedge clk); src[5] = 1'b0;
        tick(4);
        chk({7'b0, irq_n[0]}, 8'h01, "R6");
        rdchk(B_ST0, 8'h20, "R3");

        // R4 source with no edge selected
        @(negedge clk); src[1] = 1'b1;
        tick(4);
        @(negedge clk); src[1] = 1'b0;
        tick(4);
        rdchk(B_ST0, 8'h00, "R4");

        // R8 write-one-to-clear
        wr(B_CTRL, 8'h00);
        rdchk(B_ST1, 8'h21, "R8");
        rdchk(B_ST1, 8'h21, "R8");
        wr(B_ST1, 8'h01);
        rdchk(B_ST1, 8'h20, "R8");
        wr(B_ST1, 8'h20);
        rdchk(B_ST1, 8'h00, "R8");

        // R7 status writes ignored in clear-on-read, R11 test set
        wr(B_CTRL, 8'h01);
        wr(B_TS0, 8'h08);
        wr(B_ST0, 8'hFF);
        rdchk(B_ST0, 8'h08, "R11");
        rdchk(B_ST0, 8'h00, "R7");
        rdchk(B_TS0, 8'h00, "R11");

        // R9 held second event
        wr(B_CTRL, 8'h00);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); src[0] = 1'b0; tick(4);
            @(negedge clk); src[0] = 1'b1; tick(4);
        end
        wr(B_ST0, 8'h01);
        rdchk(B_ST0, 8'h01, "R9");
        wr(B_ST0, 8'h01);
        rdchk(B_ST0, 8'h00, "R9");
        wr(B_ST1, 8'h01);
        wr(B_ST1, 8'h01);
        wr(B_CTRL, 8'h02);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); src[0] = 1'b0; tick(4);
            @(negedge clk); src[0] = 1'b1; tick(4);
        end
        wr(B_ST0, 8'h01);
        rdchk(B_ST0, 8'h00, "R9");
        wr(B_ST1, 8'h01);

        // R10 clear swept across the event's arrival cycle
        wr(B_CTRL, 8'h00);
        for (int d = 0; d < 4; d++) begin
            @(negedge clk); src[0] = 1'b0; tick(4);
            wr(B_TS0, 8'h01);
            @(negedge clk); src[0] = 1'b1;
            tick(d);
            wr(B_ST0, 8'h01);
            tick(4);
            rdchk(B_ST0, 8'h01, "R10");
            wr(B_ST0, 8'h01);
            rdchk(B_ST0, 8'h00, "R10");
        end
        wr(B_ST1, 8'h01);
        wr(B_ST1, 8'h01);
        wr(B_CTRL, 8'h02);
        for (int d = 1; d < 4; d += 2) begin
            @(negedge clk); src[0] = 1'b0; tick(4);
            wr(B_TS0, 8'h01);
            @(negedge clk); src[0] = 1'b1;
            tick(d);
            wr(B_ST0, 8'h01);
            tick(4);
            if (d == 1) rdchk(B_ST0, 8'h01, "R10");
            else        rdchk(B_ST0, 8'h00, "R9");
            wr(B_ST0, 8'h01);
        end
        wr(B_ST1, 8'h01);

        // R12 byte layout and padding
        wr(B_CTRL, 8'h00);
        wr(B_TS1 + 6'd2, 8'hFF);
        rdchk(B_ST1 + 6'd2, 8'h03, "R12");
        wr(B_ST1 + 6'd2, 8'hFF);
        rdchk(B_ST1 + 6'd2, 8'h00, "R12");
        wr(B_MK1 + 6'd2, 8'hFF);
        rdchk(B_MK1 + 6'd2, 8'h03, "R12");
        wr(B_ED + 6'd4, 8'hFF);
        rdchk(B_ED + 6'd4, 8'h0F, "R12");
        wr(B_ED + 6'd4, 8'h00);
        wr(B_TS0 + 6'd1, 8'h01);
        rdchk(B_ST0 + 6'd1, 8'h01, "R12");
        rdchk(B_ST0 + 6'd2, 8'h00, "R12");
        wr(B_ST0 + 6'd1, 8'h01);

        // R13 synchronizer latency
        @(negedge clk); src[0] = 1'b0; tick(4);
        for (int b = 0; b < 3; b++) begin
            wr(B_ST0 + 6'(b), 8'hFF);
            wr(B_ST0 + 6'(b), 8'hFF);
        end
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk); chk({7'b0, irq_n[0]}, 8'h01, "R13");
        @(negedge clk); chk({7'b0, irq_n[0]}, 8'h01, "R13");
        @(negedge clk); chk({7'b0, irq_n[0]}, 8'h00, "R13");

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule